// File: doc/BRIEF.md
# Window Layer Activation Controller

This block decides, cycle by cycle during the drawing part of a scanline, whether the window layer or the background layer feeds the tile fetcher. It watches the pixel position being drawn, the current line, the window position registers and the window enable bit. It also watches a strobe from the fetcher that marks the end of each tile. From these it produces a window-active flag, a one-cycle fetcher restart pulse, a layer select, the window's internal row counter and the window's horizontal tile counter.

The vertical condition is held in a per-frame latch. The latch sets on the first cycle of the frame whose line number equals the vertical window position. The horizontal condition is an exact match between the pixel position plus seven and the horizontal window position. A match can only happen on a pixel that is being drawn, so a later re-enable cannot reopen the window at a position already drawn on the line.

Clearing the enable bit mid-line does not close the window at once. The window closes on the next tile-complete strobe, and the background then resumes tile-aligned. A valid re-opening on the same line moves the window to its next row at once.

Top module: `win_layer_ctrl`

## Requirements
- R1: After reset, win_active, fetch_restart, src_sel, bg_tile_align, win_line and win_tile_x are all 0.
- R2: The window cannot open in a frame until a cycle has occurred, after frame_start, on which cur_line equals wy. From then until the next frame_start the vertical condition stays satisfied.
- R3: On a cycle with draw_en=1, win_enable=1, the vertical condition satisfied and pix_x+7 equal to wx, the block opens the window. From the next cycle win_active=1 and src_sel=1 (1 = window, 0 = background), and fetch_restart is 1 for exactly that one cycle.
- R4: With win_enable=0, or with wx below 7, or with wx above the last drawn pixel plus 7, the window never opens on the line.
- R5: When win_enable goes low while the window is open, the window stays open until a cycle with tile_done=1. On the cycle after that strobe, win_active=0, src_sel=0, fetch_restart=1 and bg_tile_align=1.
- R6: win_tile_x becomes 0 on every window opening and increases by 1 after each tile_done cycle while the window is open.
- R7: A re-opening on the same line (a valid R3 match after an R5 close) increments win_line on the next cycle and clears bg_tile_align.
- R8: Setting win_enable again after an R5 close has no effect while wx still names a pixel that has already been drawn on this line.
- R9: win_line is 0 after frame_start. A line_end strobe increments it by 1 when the window was open at any point on that line, and otherwise leaves it unchanged.
- R10: After line_end, win_active, src_sel and bg_tile_align are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| line_end | input | 1 | One-cycle strobe at the end of each line |
| draw_en | input | 1 | High on cycles that draw the pixel at pix_x |
| pix_x | input | XW | Pixel position being drawn |
| cur_line | input | LW | Current line number |
| wx | input | XW | Horizontal window position (pixel + 7) |
| wy | input | LW | Vertical window position |
| win_enable | input | 1 | Window enable bit |
| tile_done | input | 1 | Fetcher strobe: current tile finished |
| win_active | output | 1 | Window layer currently selected |
| fetch_restart | output | 1 | One-cycle restart request to the fetcher |
| src_sel | output | 1 | Layer select, 0 background, 1 window |
| win_line | output | LW | Window internal row counter |
| win_tile_x | output | TCW | Window horizontal tile counter |
| bg_tile_align | output | 1 | Background resumed after a mid-line close; fine scroll ignored |

## Verification
The bench builds the block with XW=8, LW=8 and TCW=5, so that a full 160-pixel line and every wx value from 0 to 167 can be swept. This covers, for each wx, the exact pixel of the opening, the wx values that never match, and the row increment at the line end. An eight-line frame with wy=5 shows the vertical latch and the row count building up. A directed line covers the deferred close, the ignored re-enable at a drawn position and the same-line re-opening with its extra row step.

// File: rtl/win_ctrl_pkg.sv
// Shared types for the window layer controller.
package win_ctrl_pkg;
    // Layer feeding the tile fetcher.
    typedef enum logic {
        SRC_BG  = 1'b0,
        SRC_WIN = 1'b1
    } layer_src_e;
endpackage

// File: rtl/win_wy_gate.sv
// Per-frame vertical condition latch.
// Sets once cur_line equals wy; cleared by frame_start. Assumes frame_start
// is a single-cycle strobe.
module win_wy_gate #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [LW-1:0] cur_line,
    input  logic [LW-1:0] wy,
    output logic          wy_seen
);
    // Hold the vertical match until the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                wy_seen <= 1'b0;
        else if (frame_start)      wy_seen <= 1'b0;
        else if (cur_line == wy)   wy_seen <= 1'b1;
    end
endmodule

// File: rtl/win_x_match.sv
// Horizontal start compare: pixel position plus seven equals wx.
// Purely combinational; carries one extra bit so no wrap can alias a match.
module win_x_match #(
    parameter int XW = 8
) (
    input  logic [XW-1:0] pix_x,
    input  logic [XW-1:0] wx,
    output logic          hit
);
    localparam int SW = XW + 1;
    logic [SW-1:0] x_plus;

    // Widened sum and compare.
    always_comb begin
        x_plus = {1'b0, pix_x} + SW'(7);
        hit    = (x_plus == {1'b0, wx});
    end
endmodule

// File: rtl/win_line_ctr.sv
// Window internal row counter.
// Cleared at frame start, stepped at the end of a line that used the window
// and on each same-line re-opening. Assumes line_end and reopen never coincide.
module win_line_ctr #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_end,
    input  logic          line_used,
    input  logic          reopen,
    output logic [LW-1:0] win_line
);
    // Row count update.
    always_ff @(posedge clk) begin
        if (!rst_n)                       win_line <= '0;
        else if (frame_start)             win_line <= '0;
        else if (line_end && line_used)   win_line <= win_line + 1'b1;
        else if (reopen)                  win_line <= win_line + 1'b1;
    end

    // R9
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |->
            (win_line == $past(win_line)) || (win_line == $past(win_line) + 1'b1));

    // R9
    line_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (win_line == '0));
endmodule

// File: rtl/win_tile_ctr.sv
// Window horizontal tile counter.
// Clear has priority over advance; the count wraps at its width.
module win_tile_ctr #(
    parameter int TCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    output logic [TCW-1:0] tile_x
);
    // Tile count update.
    always_ff @(posedge clk) begin
        if (!rst_n)        tile_x <= '0;
        else if (clear)    tile_x <= '0;
        else if (advance)  tile_x <= tile_x + 1'b1;
    end
endmodule

// File: rtl/win_layer_ctrl.sv
// Window layer activation controller.
// Opens the window on an exact horizontal match once the frame's vertical
// condition holds. A disable is deferred to the next tile boundary, and a
// same-line re-opening advances the window row. Assumes frame_start and
// line_end are single-cycle strobes and pix_x advances only with draw_en.
module win_layer_ctrl
    import win_ctrl_pkg::*;
#(
    parameter int XW  = 8,
    parameter int LW  = 8,
    parameter int TCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           line_end,
    input  logic           draw_en,
    input  logic [XW-1:0]  pix_x,
    input  logic [LW-1:0]  cur_line,
    input  logic [XW-1:0]  wx,
    input  logic [LW-1:0]  wy,
    input  logic           win_enable,
    input  logic           tile_done,
    output logic           win_active,
    output logic           fetch_restart,
    output logic           src_sel,
    output logic [LW-1:0]  win_line,
    output logic [TCW-1:0] win_tile_x,
    output logic           bg_tile_align
);
    logic       wy_seen;
    logic       x_hit;
    logic       active_q, pend_q, used_q, align_q, restart_q;
    logic       boundary, open_now, reopen, close_now;
    layer_src_e src_q;

    win_wy_gate #(.LW(LW)) u_wy (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cur_line(cur_line), .wy(wy), .wy_seen(wy_seen)
    );

    win_x_match #(.XW(XW)) u_xm (
        .pix_x(pix_x), .wx(wx), .hit(x_hit)
    );

    // Open, re-open and deferred-close decisions for this cycle.
    always_comb begin
        boundary  = frame_start || line_end;
        open_now  = draw_en && win_enable && wy_seen && x_hit && !active_q && !boundary;
        reopen    = open_now && used_q;
        close_now = active_q && tile_done && (pend_q || !win_enable) && !boundary;
    end

    // Window state: active, pending disable, used-this-line, alignment, restart.
    always_ff @(posedge clk) begin
        if (!rst_n || boundary) begin
            active_q  <= 1'b0;
            pend_q    <= 1'b0;
            used_q    <= 1'b0;
            align_q   <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= open_now || close_now;
            if (open_now) begin
                active_q <= 1'b1;
                used_q   <= 1'b1;
                align_q  <= 1'b0;
                pend_q   <= 1'b0;
            end else if (close_now) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
                align_q  <= 1'b1;
            end else if (active_q && !win_enable) begin
                pend_q   <= 1'b1;
            end
        end
    end

    win_line_ctr #(.LW(LW)) u_line (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .line_used(used_q), .reopen(reopen), .win_line(win_line)
    );

    win_tile_ctr #(.TCW(TCW)) u_tile (
        .clk(clk), .rst_n(rst_n),
        .clear(open_now || boundary),
        .advance(active_q && tile_done),
        .tile_x(win_tile_x)
    );

    // Output mapping.
    assign src_q         = active_q ? SRC_WIN : SRC_BG;
    assign src_sel       = src_q;
    assign win_active    = active_q;
    assign fetch_restart = restart_q;
    assign bg_tile_align = align_q;

    // R2
    wy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> wy_seen);

    // R3
    open_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> fetch_restart);

    // R5
    close_on_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_active) && !win_active && !$past(frame_start) && !$past(line_end))
            |-> ($past(tile_done) && fetch_restart && bg_tile_align));

    // R6
    tile_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> (win_tile_x == '0));

    // R10
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_end) |-> (!win_active && !bg_tile_align && !src_sel));
endmodule

// File: tb/test_win_layer_ctrl.sv
`timescale 1ns/1ps
module test_win_layer_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, line_end = 1'b0, draw_en = 1'b0;
    logic [7:0] pix_x = '0, cur_line = '0, wx = '0, wy = '0;
    logic       win_enable = 1'b0, tile_done = 1'b0;
    logic       win_active, fetch_restart, src_sel, bg_tile_align;
    logic [7:0] win_line;
    logic [4:0] win_tile_x;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    win_layer_ctrl #(.XW(8), .LW(8), .TCW(5)) i_win_layer_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .draw_en(draw_en), .pix_x(pix_x), .cur_line(cur_line), .wx(wx), .wy(wy),
        .win_enable(win_enable), .tile_done(tile_done), .win_active(win_active),
        .fetch_restart(fetch_restart), .src_sel(src_sel), .win_line(win_line),
        .win_tile_x(win_tile_x), .bg_tile_align(bg_tile_align)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock; returns at the falling edge with outputs settled.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        draw_en = 1'b0; tile_done = 1'b0;
        cyc();
    endtask

    task automatic px(input int x, input bit td);
        draw_en = 1'b1; pix_x = 8'(x); tile_done = td;
        cyc();
        tile_done = 1'b0;
    endtask

    task automatic frame();
        draw_en = 1'b0; frame_start = 1'b1;
        cyc();
        frame_start = 1'b0;
    endtask

    task automatic eol();
        draw_en = 1'b0; line_end = 1'b1;
        cyc();
        line_end = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 win_active", win_active, 0);
        chk("R1 fetch_restart", fetch_restart, 0);
        chk("R1 src_sel", src_sel, 0);
        chk("R1 bg_tile_align", bg_tile_align, 0);
        chk("R1 win_line", win_line, 0);
        chk("R1 win_tile_x", win_tile_x, 0);

        // R3 / R4 / R9: sweep every wx over a full line
        win_enable = 1'b1; wy = 8'd0; cur_line = 8'd0;
        for (int w = 0; w < 168; w++) begin
            wx = 8'(w);
            frame();
            idle();
            for (int x = 0; x < 160; x++) begin
                bit ea, er;
                px(x, 1'b0);
                ea = (w >= 7) && (x >= w - 7);
                er = (w >= 7) && (x == w - 7);
                chk("R3/R4 win_active", win_active, int'(ea));
                chk("R3 src_sel", src_sel, int'(ea));
                chk("R3 fetch_restart", fetch_restart, int'(er));
                chk("R6 win_tile_x", win_tile_x, 0);
            end
            eol();
            chk("R9 win_line", win_line, int'((w >= 7) && (w <= 166)));
            chk("R10 win_active", win_active, 0);
        end

        // R4: enable low, matching wx
        frame(); win_enable = 1'b0; wx = 8'd30; idle();
        for (int x = 0; x < 160; x++) begin
            px(x, 1'b0);
            chk("R4 enable low", win_active, 0);
        end
        eol();
        chk("R4 win_line", win_line, 0);

        // R2 / R9: wy=5, lines 0..7
        win_enable = 1'b1; wy = 8'd5; wx = 8'd20;
        frame();
        for (int l = 0; l < 8; l++) begin
            cur_line = 8'(l);
            idle();
            for (int x = 0; x < 160; x++) begin
                px(x, 1'b0);
                chk("R2 win_active", win_active, int'((l >= 5) && (x >= 13)));
            end
            eol();
            chk("R9 win_line", win_line, (l >= 5) ? l - 4 : 0);
        end

        // R5..R8, R10: mid-line close and re-open
        wy = 8'd0; cur_line = 8'd0; wx = 8'd20; win_enable = 1'b1;
        frame(); idle();
        for (int x = 0; x <= 13; x++) px(x, 1'b0);
        chk("R3 open", win_active, 1);
        chk("R6 tile zero", win_tile_x, 0);
        px(14, 1'b1);
        chk("R6 tile step", win_tile_x, 1);
        px(15, 1'b1);
        chk("R6 tile step", win_tile_x, 2);
        win_enable = 1'b0;
        px(16, 1'b0);
        chk("R5 held open", win_active, 1);
        px(17, 1'b0);
        chk("R5 held open", win_active, 1);
        chk("R5 no align yet", bg_tile_align, 0);
        px(18, 1'b1);
        chk("R5 closed", win_active, 0);
        chk("R5 src_sel", src_sel, 0);
        chk("R5 restart", fetch_restart, 1);
        chk("R5 align", bg_tile_align, 1);
        win_enable = 1'b1;
        for (int x = 19; x < 40; x++) begin
            px(x, 1'b0);
            chk("R8 drawn wx ignored", win_active, 0);
            chk("R8 restart", fetch_restart, 0);
            chk("R8 win_line", win_line, 0);
        end
        wx = 8'd50;
        for (int x = 40; x <= 43; x++) px(x, 1'b0);
        chk("R7 reopen", win_active, 1);
        chk("R7 restart", fetch_restart, 1);
        chk("R7 win_line", win_line, 1);
        chk("R7 align cleared", bg_tile_align, 0);
        chk("R6 tile zero", win_tile_x, 0);
        for (int x = 44; x < 160; x++) px(x, 1'b0);
        chk("R7 still open", win_active, 1);
        eol();
        chk("R9 win_line", win_line, 2);
        chk("R10 win_active", win_active, 0);
        chk("R10 align", bg_tile_align, 0);
        frame();
        chk("R9 frame clear", win_line, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule